// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block places a small configuration register file behind an index/data port pair on a byte-wide I/O bus. The port at the base address holds a register index, and the port one address above reads or writes the register that index selects. The base is a parameter and may be either 0x2E or 0x4E.

Out of reset the register file is hidden. It becomes reachable only after a four-byte key is written to the index port. The final byte of that key depends on which base the block occupies. While the block is unlocked, software can read a fixed 16-bit identification code. It can also select a logical device, program six flash-control bits, and, with logical device 7 selected, set the 16-bit I/O base of a downstream SPI engine. The control bits and the SPI base leave the block as plain signals. A specific write to the exit register locks the block again.

Bus cycles are single-cycle strobes. A write takes effect at the next rising clock edge. Read data is combinational from the address, the read strobe and the current state.

Top module: `cfg_unlock_ctl`

## Requirements
- R1: While unlocked, a write to the index port (base) loads the index. A read of the index port returns the current index. Reads and writes at the data port (base+1) reach the register that the index selects.
- R2: The block unlocks after four consecutive index-port writes of 0x87, 0x01, 0x55 and a final byte. The final byte is 0x55 at base 0x2E and 0xAA at base 0x4E. The `cfg_unlocked` output goes high at the clock edge that takes the fourth byte.
- R3: An index-port write that does not match the next expected key byte returns the detector to its start. A mismatching 0x87 counts as the first key byte, so the next byte expected is 0x01. Cycles at any other address do not disturb the partial key.
- R4: While unlocked, writing 0x02 to register 0x02 locks the block at that edge. Writing any other value to register 0x02 leaves the block unlocked.
- R5: While locked, reads of both ports return 0xFF, data-port writes change no register, and index-port writes feed only the key detector.
- R6: Registers 0x20 and 0x21 read 0x87 and 0x16. Both are read-only.
- R7: Register 0x07 is the read/write logical-device number. Registers 0x64 and 0x65 hold the high and low bytes of `spi_io_base` and are accessible only when the device number is 7. With any other device number they read 0x00 and ignore writes.
- R8: Register 0x24 keeps bits 5:0 and reads bits 7:6 as zero. Bit 0 drives `flash_suspend`, bit 1 drives `seg_top_en`, bit 2 drives `seg_ffee_en`, bit 3 drives `seg_fff8_en`, bit 4 drives `flash_lpc_wr_en` and bit 5 drives `flash_cs_alt`.
- R9: After reset the block is locked, the key detector is at its start, and the index, device number and register 0x24 are zero. `spi_io_base` equals the SPI_BASE_RST parameter (default 0x0820).
- R10: Addresses other than base and base+1 are ignored and read 0x00. `io_rdata` is 0x00 in any cycle without `io_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the current cycle |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| cfg_unlocked | output | 1 | High while the register file is reachable |
| flash_suspend | output | 1 | Register 0x24 bit 0 |
| seg_top_en | output | 1 | Register 0x24 bit 1 |
| seg_ffee_en | output | 1 | Register 0x24 bit 2 |
| seg_fff8_en | output | 1 | Register 0x24 bit 3 |
| flash_lpc_wr_en | output | 1 | Register 0x24 bit 4 |
| flash_cs_alt | output | 1 | Register 0x24 bit 5 |
| spi_io_base | output | 16 | I/O base of the downstream SPI engine |

## Verification
The hardest cases to reach are partial-key states that a plain unlock never visits. Examples are a 0x87 arriving where 0x55 was expected, a data-port cycle wedged inside a key, and the wrong final byte for this base. The stimulus drives these deliberately, and a behavioural model tracks the key position, so a detector that restarts in the wrong place shows up within a cycle. A second instance at base 0x4E receives the same bus. It must stay locked under the 0x2E key and open only on 0xAA.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

   // key sequence written to the index port
   localparam int          KEY_LEN     = 4;
   localparam logic [7:0]  KEY_B0      = 8'h87;
   localparam logic [7:0]  KEY_B1      = 8'h01;
   localparam logic [7:0]  KEY_B2      = 8'h55;
   localparam logic [7:0]  KEY_END_2E  = 8'h55;
   localparam logic [7:0]  KEY_END_4E  = 8'hAA;

   // register indices
   localparam logic [7:0]  IDX_EXIT    = 8'h02;
   localparam logic [7:0]  IDX_LDN     = 8'h07;
   localparam logic [7:0]  IDX_ID_HI   = 8'h20;
   localparam logic [7:0]  IDX_ID_LO   = 8'h21;
   localparam logic [7:0]  IDX_FCTL    = 8'h24;
   localparam logic [7:0]  IDX_SPI_HI  = 8'h64;
   localparam logic [7:0]  IDX_SPI_LO  = 8'h65;

   localparam logic [7:0]  EXIT_VAL    = 8'h02;
   localparam logic [7:0]  FILL_LOCKED = 8'hFF;

   // flash control field, bit 0 at the bottom
   typedef struct packed {
      logic cs_alt;
      logic lpc_wr;
      logic seg_fff8;
      logic seg_ffee;
      logic seg_top;
      logic suspend;
   } fctl_t;

   localparam int FCTL_W = $bits(fctl_t);

   function automatic logic [7:0] key_end(input logic [15:0] base);
      return (base == 16'h004E) ? KEY_END_4E : KEY_END_2E;
   endfunction

endpackage

// File: rtl/cfg_bus_port.sv
module cfg_bus_port #(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h2E
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic              idx_wr,
   output logic              idx_rd,
   output logic              dat_wr,
   output logic              dat_rd
);

   localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE_ADDR + 1);

   if (ADDR_W < 8) begin : g_bad_width
      $error("cfg_bus_port: ADDR_W must be at least 8");
   end
   if (BASE_ADDR[0] != 1'b0) begin : g_bad_align
      $error("cfg_bus_port: BASE_ADDR must be even");
   end

   logic hit_idx;
   logic hit_dat;

   always_comb begin
      hit_idx = (io_addr == BASE_ADDR);
      hit_dat = (io_addr == DATA_ADDR);
      idx_wr  = io_wr & hit_idx;
      idx_rd  = io_rd & hit_idx;
      dat_wr  = io_wr & hit_dat;
      dat_rd  = io_rd & hit_dat;
   end

endmodule

// File: rtl/cfg_key_seq.sv
module cfg_key_seq
   import cfg_unlock_pkg::*;
#(
   parameter logic [15:0] BASE_ADDR = 16'h002E
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_wr,
   input  logic [7:0] key_byte,
   input  logic       relock,
   output logic       unlocked
);

   localparam int STEP_W = $clog2(KEY_LEN);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);

   logic [7:0]        key_tbl [KEY_LEN];
   logic [STEP_W-1:0] step_q;
   logic              unl_q;
   logic [7:0]        want;

   assign key_tbl[0] = KEY_B0;
   assign key_tbl[1] = KEY_B1;
   assign key_tbl[2] = KEY_B2;

   // last key byte depends on which base the block sits at
   if (BASE_ADDR == 16'h002E) begin : g_end_2e
      assign key_tbl[KEY_LEN-1] = KEY_END_2E;
   end else if (BASE_ADDR == 16'h004E) begin : g_end_4e
      assign key_tbl[KEY_LEN-1] = KEY_END_4E;
   end else begin : g_end_bad
      assign key_tbl[KEY_LEN-1] = KEY_END_2E;
      $error("cfg_key_seq: BASE_ADDR must be 0x2E or 0x4E");
   end

   assign want = key_tbl[step_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         unl_q  <= 1'b0;
      end else if (relock) begin
         step_q <= '0;
         unl_q  <= 1'b0;
      end else if (key_wr && !unl_q) begin
         if (key_byte == want) begin
            if (step_q == LAST_STEP) begin
               step_q <= '0;
               unl_q  <= 1'b1;
            end else begin
               step_q <= step_q + 1'b1;
            end
         end else if (key_byte == KEY_B0) begin
            step_q <= STEP_W'(1);
         end else begin
            step_q <= '0;
         end
      end
   end

   assign unlocked = unl_q;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
   import cfg_unlock_pkg::*;
#(
   parameter logic [15:0] CHIP_ID      = 16'h8716,
   parameter logic [15:0] SPI_BASE_RST = 16'h0820,
   parameter logic [7:0]  SPI_LDN      = 8'h07
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        unlocked,
   input  logic        idx_wr,
   input  logic        dat_wr,
   input  logic [7:0]  wdata,
   output logic [7:0]  idx_q,
   output logic [7:0]  ldn_q,
   output fctl_t       fctl_q,
   output logic [15:0] spi_base_q,
   output logic [7:0]  rd_byte,
   output logic        relock
);

   if (FCTL_W > 8) begin : g_bad_fctl
      $error("cfg_regfile: flash control field wider than a byte");
   end

   logic spi_open;
   logic wr_ok;

   assign spi_open = (ldn_q == SPI_LDN);
   assign wr_ok    = unlocked & dat_wr;
   assign relock   = wr_ok & (idx_q == IDX_EXIT) & (wdata == EXIT_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (unlocked && idx_wr) begin
         idx_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ldn_q      <= '0;
         fctl_q     <= '0;
         spi_base_q <= SPI_BASE_RST;
      end else if (wr_ok) begin
         unique case (idx_q)
            IDX_LDN:    ldn_q  <= wdata;
            IDX_FCTL:   fctl_q <= fctl_t'(wdata[FCTL_W-1:0]);
            IDX_SPI_HI: if (spi_open) spi_base_q[15:8] <= wdata;
            IDX_SPI_LO: if (spi_open) spi_base_q[7:0]  <= wdata;
            default:    ;
         endcase
      end
   end

   always_comb begin
      rd_byte = '0;
      unique case (idx_q)
         IDX_LDN:    rd_byte = ldn_q;
         IDX_ID_HI:  rd_byte = CHIP_ID[15:8];
         IDX_ID_LO:  rd_byte = CHIP_ID[7:0];
         IDX_FCTL:   rd_byte = 8'(fctl_q);
         IDX_SPI_HI: rd_byte = spi_open ? spi_base_q[15:8] : 8'h00;
         IDX_SPI_LO: rd_byte = spi_open ? spi_base_q[7:0]  : 8'h00;
         default:    rd_byte = '0;
      endcase
   end

endmodule

// File: rtl/cfg_unlock_ctl.sv
module cfg_unlock_ctl
   import cfg_unlock_pkg::*;
#(
   parameter int                ADDR_W       = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR    = 'h2E,
   parameter logic [15:0]       CHIP_ID      = 16'h8716,
   parameter logic [15:0]       SPI_BASE_RST = 16'h0820,
   parameter logic [7:0]        SPI_LDN      = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic              cfg_unlocked,
   output logic              flash_suspend,
   output logic              seg_top_en,
   output logic              seg_ffee_en,
   output logic              seg_fff8_en,
   output logic              flash_lpc_wr_en,
   output logic              flash_cs_alt,
   output logic [15:0]       spi_io_base
);

   logic        idx_wr, idx_rd, dat_wr, dat_rd;
   logic        relock;
   logic        unl;
   logic [7:0]  idx_q, ldn_q, rd_byte;
   fctl_t       fctl_q;
   logic [15:0] spi_base_q;

   cfg_bus_port #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_port (
      .io_addr (io_addr),
      .io_wr   (io_wr),
      .io_rd   (io_rd),
      .idx_wr  (idx_wr),
      .idx_rd  (idx_rd),
      .dat_wr  (dat_wr),
      .dat_rd  (dat_rd)
   );

   cfg_key_seq #(
      .BASE_ADDR (16'(BASE_ADDR))
   ) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (idx_wr),
      .key_byte (io_wdata),
      .relock   (relock),
      .unlocked (unl)
   );

   cfg_regfile #(
      .CHIP_ID      (CHIP_ID),
      .SPI_BASE_RST (SPI_BASE_RST),
      .SPI_LDN      (SPI_LDN)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .unlocked   (unl),
      .idx_wr     (idx_wr),
      .dat_wr     (dat_wr),
      .wdata      (io_wdata),
      .idx_q      (idx_q),
      .ldn_q      (ldn_q),
      .fctl_q     (fctl_q),
      .spi_base_q (spi_base_q),
      .rd_byte    (rd_byte),
      .relock     (relock)
   );

   always_comb begin
      io_rdata = 8'h00;
      if (idx_rd) begin
         io_rdata = unl ? idx_q : FILL_LOCKED;
      end else if (dat_rd) begin
         io_rdata = unl ? rd_byte : FILL_LOCKED;
      end
   end

   assign cfg_unlocked    = unl;
   assign flash_suspend   = fctl_q.suspend;
   assign seg_top_en      = fctl_q.seg_top;
   assign seg_ffee_en     = fctl_q.seg_ffee;
   assign seg_fff8_en     = fctl_q.seg_fff8;
   assign flash_lpc_wr_en = fctl_q.lpc_wr;
   assign flash_cs_alt    = fctl_q.cs_alt;
   assign spi_io_base     = spi_base_q;

endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk
   import cfg_unlock_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h2E,
   parameter logic [7:0]        SPI_LDN   = 8'h07
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic              cfg_unlocked,
   input logic [15:0]       spi_io_base,
   input logic [7:0]        idx,
   input logic [7:0]        ldn
);

   localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE_ADDR + 1);
   localparam logic [7:0]        END_BYTE  = key_end(16'(BASE_ADDR));

   // R2
   unlock_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_unlocked) |-> $past(io_wr) && $past(io_addr) == BASE_ADDR
                              && $past(io_wdata) == END_BYTE);

   // R4
   relock_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_unlocked) |-> $past(io_wr) && $past(io_addr) == DATA_ADDR
                              && $past(idx) == IDX_EXIT && $past(io_wdata) == EXIT_VAL);

   // R5
   locked_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_unlocked && io_rd && (io_addr == BASE_ADDR || io_addr == DATA_ADDR))
         |-> io_rdata == FILL_LOCKED);

   // R1
   index_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_unlocked && io_rd && io_addr == BASE_ADDR) |-> io_rdata == idx);

   // R7
   spi_base_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spi_io_base) |-> $past(io_wr) && $past(ldn) == SPI_LDN
                                && $past(cfg_unlocked));

   // R10
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> io_rdata == 8'h00);

endmodule

bind cfg_unlock_ctl cfg_unlock_chk #(
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR),
   .SPI_LDN   (SPI_LDN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .io_addr      (io_addr),
   .io_wr        (io_wr),
   .io_rd        (io_rd),
   .io_wdata     (io_wdata),
   .io_rdata     (io_rdata),
   .cfg_unlocked (cfg_unlocked),
   .spi_io_base  (spi_io_base),
   .idx          (idx_q),
   .ldn          (ldn_q)
);

// File: tb/test_cfg_unlock_ctl.sv
module test_cfg_unlock_ctl;

   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] IP  = 16'h002E;
   localparam logic [15:0] DP  = 16'h002F;
   localparam logic [15:0] IP2 = 16'h004E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata, io_rdata2;
   logic        unl, unl2;
   logic        f_sus, f_top, f_ffee, f_fff8, f_wr, f_cs;
   logic        g_sus, g_top, g_ffee, g_fff8, g_wr, g_cs;
   logic [15:0] spi, spi2;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural model of the 0x2E instance
   int m_unl, m_step, m_idx, m_ldn, m_fctl, m_spi;
   int key[4] = '{8'h87, 8'h01, 8'h55, 8'h55};

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_unlock_ctl i_cfg_unlock_ctl (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_unlocked(unl),
      .flash_suspend(f_sus), .seg_top_en(f_top), .seg_ffee_en(f_ffee),
      .seg_fff8_en(f_fff8), .flash_lpc_wr_en(f_wr), .flash_cs_alt(f_cs),
      .spi_io_base(spi)
   );

   cfg_unlock_ctl #(.BASE_ADDR(16'h004E)) i_cfg_unlock_ctl_4e (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata2), .cfg_unlocked(unl2),
      .flash_suspend(g_sus), .seg_top_en(g_top), .seg_ffee_en(g_ffee),
      .seg_fff8_en(g_fff8), .flash_lpc_wr_en(g_wr), .flash_cs_alt(g_cs),
      .spi_io_base(spi2)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic int reg_val(input int i);
      case (i)
         8'h07:   return m_ldn;
         8'h20:   return 8'h87;
         8'h21:   return 8'h16;
         8'h24:   return m_fctl;
         8'h64:   return (m_ldn == 7) ? (m_spi >> 8) : 0;
         8'h65:   return (m_ldn == 7) ? (m_spi & 8'hFF) : 0;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_rdata(input bit rd, input int a);
      if (!rd) return 0;
      if (a == IP) return m_unl ? m_idx : 8'hFF;
      if (a == DP) return m_unl ? reg_val(m_idx) : 8'hFF;
      return 0;
   endfunction

   task automatic model_apply(input bit wr, input int a, input int d);
      if (!wr) return;
      if (a == IP) begin
         if (m_unl != 0) m_idx = d;
         else if (d == key[m_step]) begin
            if (m_step == 3) begin m_unl = 1; m_step = 0; end
            else m_step++;
         end else m_step = (d == 8'h87) ? 1 : 0;
      end else if (a == DP && m_unl != 0) begin
         case (m_idx)
            8'h02: if (d == 2) begin m_unl = 0; m_step = 0; end
            8'h07: m_ldn = d;
            8'h24: m_fctl = d & 8'h3F;
            8'h64: if (m_ldn == 7) m_spi = (d << 8) | (m_spi & 8'hFF);
            8'h65: if (m_ldn == 7) m_spi = (m_spi & 16'hFF00) | d;
            default: ;
         endcase
      end
   endtask

   // one bus cycle; every output compared against the model
   task automatic cyc(input bit wr, input bit rd, input logic [15:0] a,
                      input logic [7:0] d, input string tag);
      @(negedge clk);
      io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
      #1;
      check(tag, "rdata", int'(io_rdata), exp_rdata(rd, int'(a)));
      check(tag, "unlocked", int'(unl), m_unl);
      check(tag, "fctl outputs", int'({f_cs, f_wr, f_fff8, f_ffee, f_top, f_sus}), m_fctl);
      check(tag, "spi base", int'(spi), m_spi);
      model_apply(wr, int'(a), int'(d));
   endtask

   task automatic idle(input string tag);
      cyc(1'b0, 1'b0, 16'h0000, 8'h00, tag);
   endtask

   task automatic key_2e(input string tag);
      cyc(1, 0, IP, 8'h87, tag);
      cyc(1, 0, IP, 8'h01, tag);
      cyc(1, 0, IP, 8'h55, tag);
      cyc(1, 0, IP, 8'h55, tag);
   endtask

   task automatic wreg(input logic [7:0] i, input logic [7:0] d, input string tag);
      cyc(1, 0, IP, i, tag);
      cyc(1, 0, DP, d, tag);
   endtask

   task automatic rreg(input logic [7:0] i, input string tag);
      cyc(1, 0, IP, i, tag);
      cyc(0, 1, DP, 8'h00, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      m_unl = 0; m_step = 0; m_idx = 0; m_ldn = 0; m_fctl = 0; m_spi = 16'h0820;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      idle("R9");
      idle("R9");

      // R5 locked behaviour
      cyc(0, 1, DP, 8'h00, "R5");
      cyc(0, 1, IP, 8'h00, "R5");
      cyc(1, 0, DP, 8'h3F, "R5");
      cyc(0, 1, DP, 8'h00, "R5");

      // R3 mismatch restarts, 0x87 resyncs, other addresses harmless
      cyc(1, 0, IP, 8'h87, "R3");
      cyc(1, 0, IP, 8'h01, "R3");
      cyc(1, 0, IP, 8'h12, "R3");
      cyc(1, 0, IP, 8'h55, "R3");
      cyc(1, 0, IP, 8'h55, "R3");
      idle("R3");
      cyc(1, 0, IP, 8'h87, "R3");
      cyc(1, 0, IP, 8'h01, "R3");
      cyc(1, 0, IP, 8'h87, "R3");
      cyc(1, 0, IP, 8'h01, "R3");
      cyc(1, 0, DP, 8'h77, "R3");
      cyc(0, 1, 16'h0030, 8'h00, "R3");
      cyc(1, 0, 16'h0031, 8'h55, "R3");
      cyc(1, 0, IP, 8'h55, "R3");
      cyc(1, 0, IP, 8'h55, "R3");
      idle("R3");

      // R4 relock
      wreg(8'h02, 8'h01, "R4");
      idle("R4");
      wreg(8'h02, 8'h02, "R4");
      cyc(0, 1, DP, 8'h00, "R4");

      // R2 wrong final byte keeps locked at base 0x2E
      cyc(1, 0, IP, 8'h87, "R2");
      cyc(1, 0, IP, 8'h01, "R2");
      cyc(1, 0, IP, 8'h55, "R2");
      cyc(1, 0, IP, 8'hAA, "R2");
      idle("R2");
      key_2e("R2");
      idle("R2");

      // R5 earlier locked writes left nothing behind
      rreg(8'h24, "R5");

      // R1 index readback and register access
      cyc(1, 0, IP, 8'h21, "R1");
      cyc(0, 1, IP, 8'h00, "R1");
      cyc(0, 1, DP, 8'h00, "R1");

      // R6 chip id read-only
      rreg(8'h20, "R6");
      cyc(1, 0, DP, 8'h00, "R6");
      cyc(0, 1, DP, 8'h00, "R6");
      rreg(8'h21, "R6");

      // R8 flash control bits
      wreg(8'h24, 8'hFF, "R8");
      cyc(0, 1, DP, 8'h00, "R8");
      wreg(8'h24, 8'h15, "R8");
      cyc(0, 1, DP, 8'h00, "R8");
      wreg(8'h24, 8'h2A, "R8");
      idle("R8");

      // R7 SPI base gated by device number
      rreg(8'h64, "R7");
      wreg(8'h64, 8'h12, "R7");
      idle("R7");
      wreg(8'h07, 8'h07, "R7");
      rreg(8'h07, "R7");
      rreg(8'h64, "R7");
      wreg(8'h64, 8'h12, "R7");
      wreg(8'h65, 8'h34, "R7");
      rreg(8'h65, "R7");
      wreg(8'h07, 8'h03, "R7");
      rreg(8'h64, "R7");
      wreg(8'h65, 8'h99, "R7");
      idle("R7");

      // R10 foreign addresses and idle reads
      cyc(0, 1, 16'h0030, 8'h00, "R10");
      cyc(1, 0, 16'h012E, 8'h07, "R10");
      cyc(0, 1, IP, 8'h00, "R10");
      idle("R10");

      // R2 base 0x4E instance: 0x55 final byte fails, 0xAA opens
      cyc(1, 0, IP2, 8'h87, "R2");
      cyc(1, 0, IP2, 8'h01, "R2");
      cyc(1, 0, IP2, 8'h55, "R2");
      cyc(1, 0, IP2, 8'h55, "R2");
      check("R2", "4E unlocked after 0x55", int'(unl2), 0);
      cyc(1, 0, IP2, 8'h87, "R2");
      cyc(1, 0, IP2, 8'h01, "R2");
      cyc(1, 0, IP2, 8'h55, "R2");
      check("R2", "4E unlocked before last", int'(unl2), 0);
      cyc(1, 0, IP2, 8'hAA, "R2");
      idle("R2");
      check("R2", "4E unlocked after 0xAA", int'(unl2), 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule